// File: doc/BRIEF.md
# Hub Microframe and Frame Timer Synchronizer

This block keeps a hub's 125 µs microframe timer aligned to the high-speed start-of-frame (SOF) packets sent by the host. Each SOF carries an 11-bit frame number. The block runs a cycle counter whose period is one microframe. An SOF that arrives close enough to the expected boundary re-aligns that counter. An SOF that arrives elsewhere is treated as if it had never been seen.

Once the microframe timer is locked, the block looks for the first microframe of a 1 ms frame. This is the SOF whose frame number is one greater (modulo 2048) than the frame number of the SOF in the microframe just before it. From that point the block reports frame lock and a running microframe index from 0 to 7. When three microframes in a row pass without an accepted SOF, all lock is dropped. The upstream-connect enable then goes low, because the end-of-frame point is no longer known. Downstream connectivity is not gated by this block, and generating downstream SOF packets is also outside the block.

All timer lengths are parameters counted in clock cycles, so short periods can be used in simulation.

Top module: `hub_frame_sync`

## Requirements
- R1: After reset, `uframe_sync`, `frame_sync`, `upstream_en` and `uframe_idx` are all 0.
- R2: While unlocked, any SOF pulse sets `uframe_sync` and `upstream_en` on the following clock edge. That SOF cycle becomes cycle 0 of a microframe, and the next boundary is expected `UFRAME_CYCLES` cycles later.
- R3: While locked, an SOF that arrives d cycles after the expected boundary, with -`WIN_CYCLES` <= d <= `WIN_CYCLES`-1, is accepted. The cycle in which it arrives becomes cycle 0 of the microframe.
- R4: While locked, an SOF outside that window is ignored. It leaves `uframe_idx` and `frame_sync` as if no SOF had come, even when its frame number would mark a zeroth microframe.
- R5: A microframe counts as missed when no SOF has been accepted by `WIN_CYCLES` cycles after its boundary. An accepted SOF clears the miss count. On the third consecutive miss, `uframe_sync` drops in the same cycle that the miss is detected.
- R6: When two SOFs are accepted in consecutive microframes and the second frame number equals the first plus 1 modulo 2^11 (so 2047 is followed by 0), then after the second SOF `frame_sync` = 1 and `uframe_idx` = 0.
- R7: A repeated frame number does not give frame lock. Two SOFs separated by a missed microframe do not give frame lock either.
- R8: While locked, `uframe_idx` advances by exactly one per microframe, modulo 8. It advances once even when an early SOF lands on the cycle where the counter would have wrapped anyway.
- R9: `frame_sync` stays at 1 for as long as `uframe_sync` stays at 1, even when later frame numbers jump.
- R10: Losing microframe lock clears `frame_sync`, forces `uframe_idx` to 0 and drives `upstream_en` low.
- R11: `upstream_en` is 1 exactly when `uframe_sync` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof_valid | input | 1 | One-cycle pulse: a good high-speed SOF was received |
| sof_frame | input | FNUM_W | Frame number carried by that SOF |
| uframe_sync | output | 1 | Microframe timer is locked |
| frame_sync | output | 1 | Frame timer is locked (zeroth microframe found) |
| uframe_idx | output | $clog2(UFRAMES) | Microframe index within the frame |
| upstream_en | output | 1 | Upstream connectivity may be established |

## Verification
Two things can happen in the same cycle: the counter's own wrap at the end of a microframe, and the arrival of an early SOF. If both acted separately, the index would step twice. The bench provokes this by sending an SOF exactly one cycle before the nominal boundary and checking that the index moved by one. It also sends a late SOF just after the wrap and checks that this SOF causes no second step. A random phase sends in-window SOFs with random early and late offsets across the 2047-to-0 frame-number rollover. It compares the index against a bench model of the frame position.

// File: rtl/hub_sync_pkg.sv
// Shared types for the microframe/frame timer synchronizer.
// Assumes nothing beyond plain SystemVerilog packages.
package hub_sync_pkg;

    // Where the microframe counter currently stands relative to the SOF window
    typedef enum logic [1:0] {
        PH_OUTSIDE = 2'd0,   // an SOF here is ignored
        PH_ONTIME  = 2'd1,   // exactly on the boundary
        PH_LATE    = 2'd2,   // shortly after the boundary
        PH_EARLY   = 2'd3    // shortly before the next boundary
    } sof_phase_e;

endpackage

// File: rtl/uframe_counter.sv
// Microframe cycle counter. It counts PERIOD cycles per microframe while locked.
// An accepted SOF re-aligns it so that the SOF cycle is cycle 0.
// It classifies the current cycle against the SOF acceptance window.
// Assumes 2*WIN < PERIOD and WIN >= 1.
module uframe_counter
    import hub_sync_pkg::*;
#(
    parameter int PERIOD = 60000,
    parameter int WIN    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked,
    input  logic       accept,
    output sof_phase_e phase,
    output logic       at_wrap,
    output logic       at_check
);
    localparam int CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt;

    // Count through the microframe, re-aligning on an accepted SOF
    always_ff @(posedge clk) begin : p_count
        if (!rst_n)                             cnt <= '0;
        else if (accept)                        cnt <= CNT_W'(1);
        else if (!locked)                       cnt <= '0;
        else if (cnt == CNT_W'(PERIOD - 1))     cnt <= '0;
        else                                    cnt <= cnt + 1'b1;
    end

    // Classify the current cycle against the acceptance window
    always_comb begin : p_phase
        if (cnt == '0)                          phase = PH_ONTIME;
        else if (cnt < CNT_W'(WIN))             phase = PH_LATE;
        else if (cnt >= CNT_W'(PERIOD - WIN))   phase = PH_EARLY;
        else                                    phase = PH_OUTSIDE;
    end

    assign at_wrap  = locked && (cnt == CNT_W'(PERIOD - 1));
    assign at_check = locked && (cnt == CNT_W'(WIN));

endmodule

// File: rtl/sync_tracker.sv
// Microframe lock tracker. It locks on an accepted SOF and counts microframes
// in which no SOF was accepted before the window closed. It drops lock on
// MISS_LIMIT consecutive misses.
// Assumes at_check/at_wrap are only asserted while locked.
module sync_tracker #(
    parameter int MISS_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic at_wrap,
    input  logic at_check,
    output logic locked,
    output logic miss_now,
    output logic lose
);
    localparam int MW = $clog2(MISS_LIMIT + 1);

    logic          got;
    logic [MW-1:0] miss_cnt;

    assign miss_now = at_check && !got;
    assign lose     = miss_now && (miss_cnt == MW'(MISS_LIMIT - 1));

    // Lock state: set by an accepted SOF, cleared on the final miss
    always_ff @(posedge clk) begin : p_lock
        if (!rst_n)      locked <= 1'b0;
        else if (lose)   locked <= 1'b0;
        else if (accept) locked <= 1'b1;
    end

    // Remember whether the current microframe has had its SOF
    always_ff @(posedge clk) begin : p_got
        if (!rst_n || lose) got <= 1'b0;
        else if (accept)    got <= 1'b1;
        else if (at_wrap)   got <= 1'b0;
    end

    // Consecutive miss counter
    always_ff @(posedge clk) begin : p_miss
        if (!rst_n || lose || accept) miss_cnt <= '0;
        else if (miss_now)            miss_cnt <= miss_cnt + 1'b1;
    end

endmodule

// File: rtl/frame_locator.sv
// Finds the zeroth microframe from consecutive SOF frame numbers and keeps
// the microframe index. Frame lock is held until microframe lock is lost.
// Assumes 'advance' pulses once per microframe while locked.
module frame_locator #(
    parameter int FNUM_W  = 11,
    parameter int UFRAMES = 8,
    localparam int IDX_W  = $clog2(UFRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              accept,
    input  logic [FNUM_W-1:0] sof_frame,
    input  logic              advance,
    input  logic              miss_now,
    input  logic              lose,
    output logic              frame_sync,
    output logic [IDX_W-1:0]  idx
);
    logic [FNUM_W-1:0] last_frame;
    logic              last_ok;
    logic              zeroth;

    assign zeroth = accept && locked && last_ok &&
                    (sof_frame == last_frame + FNUM_W'(1));

    // Frame number of the last accepted SOF and whether it is still adjacent
    always_ff @(posedge clk) begin : p_last
        if (!rst_n || lose) begin
            last_ok    <= 1'b0;
            last_frame <= '0;
        end else if (accept) begin
            last_ok    <= 1'b1;
            last_frame <= sof_frame;
        end else if (miss_now) begin
            last_ok    <= 1'b0;
        end
    end

    // Frame lock: set at the zeroth microframe, cleared with microframe lock
    always_ff @(posedge clk) begin : p_fsync
        if (!rst_n || lose) frame_sync <= 1'b0;
        else if (zeroth)    frame_sync <= 1'b1;
    end

    // Microframe index within the frame
    always_ff @(posedge clk) begin : p_idx
        if (!rst_n || lose || zeroth)         idx <= '0;
        else if (advance) begin
            if (idx == IDX_W'(UFRAMES - 1))   idx <= '0;
            else                              idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/hub_frame_sync.sv
// Top of the hub microframe/frame timer synchronizer. It accepts SOF pulses
// with frame numbers and reports microframe lock, frame lock, the microframe
// index and the upstream-connect enable.
// Assumes sof_valid is a single-cycle pulse and 2*WIN_CYCLES < UFRAME_CYCLES.
module hub_frame_sync
    import hub_sync_pkg::*;
#(
    parameter int UFRAME_CYCLES = 60000,
    parameter int WIN_CYCLES    = 8,
    parameter int MISS_LIMIT    = 3,
    parameter int FNUM_W        = 11,
    parameter int UFRAMES       = 8,
    localparam int IDX_W        = $clog2(UFRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof_valid,
    input  logic [FNUM_W-1:0] sof_frame,
    output logic              uframe_sync,
    output logic              frame_sync,
    output logic [IDX_W-1:0]  uframe_idx,
    output logic              upstream_en
);
    sof_phase_e phase;
    logic       locked, accept, at_wrap, at_check, miss_now, lose, advance;

    assign accept  = sof_valid && (!locked || (phase != PH_OUTSIDE));
    assign advance = locked && ((accept && (phase == PH_EARLY)) ||
                                (at_wrap && !accept));

    uframe_counter #(.PERIOD(UFRAME_CYCLES), .WIN(WIN_CYCLES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .locked(locked), .accept(accept),
        .phase(phase), .at_wrap(at_wrap), .at_check(at_check)
    );

    sync_tracker #(.MISS_LIMIT(MISS_LIMIT)) u_trk (
        .clk(clk), .rst_n(rst_n), .accept(accept), .at_wrap(at_wrap),
        .at_check(at_check), .locked(locked), .miss_now(miss_now), .lose(lose)
    );

    frame_locator #(.FNUM_W(FNUM_W), .UFRAMES(UFRAMES)) u_frm (
        .clk(clk), .rst_n(rst_n), .locked(locked), .accept(accept),
        .sof_frame(sof_frame), .advance(advance), .miss_now(miss_now),
        .lose(lose), .frame_sync(frame_sync), .idx(uframe_idx)
    );

    assign uframe_sync = locked;
    assign upstream_en = locked;

endmodule

// File: rtl/hub_frame_sync_checker.sv
// Property checker for hub_frame_sync, attached by bind.
// It observes the top-level ports only.
module hub_frame_sync_checker #(
    parameter int UFRAMES = 8,
    localparam int IDX_W  = $clog2(UFRAMES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof_valid,
    input logic             uframe_sync,
    input logic             frame_sync,
    input logic [IDX_W-1:0] uframe_idx
);
    // R2: an SOF while unlocked always locks
    p_lock_on_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!uframe_sync && sof_valid) |=> uframe_sync);

    // R6: frame lock rises only at index 0
    p_zeroth_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_sync) |-> (uframe_idx == '0));

    // R9: frame lock is held while microframe lock is held
    p_fsync_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_sync) && uframe_sync) |-> frame_sync);

    // R10: no frame lock and zero index without microframe lock
    p_fsync_needs_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !uframe_sync |-> (!frame_sync && uframe_idx == '0));

    // R8: while frame-locked the index holds, steps by one, or restarts at 0
    p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && $past(frame_sync)) |->
        (uframe_idx == $past(uframe_idx) || uframe_idx == '0 ||
         uframe_idx == $past(uframe_idx) + 1'b1));

endmodule

bind hub_frame_sync hub_frame_sync_checker #(.UFRAMES(UFRAMES)) u_chk (
    .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid),
    .uframe_sync(uframe_sync), .frame_sync(frame_sync), .uframe_idx(uframe_idx)
);

// File: tb/tb_hub_frame_sync.sv
module tb_hub_frame_sync;
    localparam int P   = 40;
    localparam int WIN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        uframe_sync, frame_sync, upstream_en;
    logic [2:0]  uframe_idx;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    hub_frame_sync #(.UFRAME_CYCLES(P), .WIN_CYCLES(WIN), .MISS_LIMIT(3),
                     .FNUM_W(11), .UFRAMES(8)) dut (
        .clk(clk), .rst_n(rst_n), .sof_valid(sof_valid), .sof_frame(sof_frame),
        .uframe_sync(uframe_sync), .frame_sync(frame_sync),
        .uframe_idx(uframe_idx), .upstream_en(upstream_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Drive one cycle of input at a negedge; return at the next negedge
    task automatic cyc(input bit v, input logic [10:0] f);
        sof_valid = v;
        sof_frame = f;
        @(negedge clk);
        sof_valid = 1'b0;
    endtask

    // SOF arriving 'gap' cycles after the previous SOF
    task automatic sof_after(input int gap, input logic [10:0] f);
        repeat (gap - 1) cyc(1'b0, '0);
        cyc(1'b1, f);
    endtask

    function automatic logic [10:0] fnum_at(input int base, input int pos);
        return 11'((base + pos / 8) & 11'h7FF);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int m0;
        bit seen0;
        void'($urandom(32'd2024));
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 uframe_sync", uframe_sync, 0);
        chk_eq("R1 frame_sync", frame_sync, 0);
        chk_eq("R1 upstream_en", upstream_en, 0);
        chk_eq("R1 uframe_idx", uframe_idx, 0);

        // R2 lock on first SOF
        cyc(1'b1, 11'd100);
        chk_eq("R2 uframe_sync", uframe_sync, 1);
        chk_eq("R11 upstream_en", upstream_en, 1);
        chk_eq("R2 frame_sync", frame_sync, 0);

        // R7 repeated frame number gives no frame lock
        sof_after(P, 11'd100);
        chk_eq("R7 repeat frame_sync", frame_sync, 0);
        // R6 increment gives zeroth microframe
        sof_after(P, 11'd101);
        chk_eq("R6 frame_sync", frame_sync, 1);
        chk_eq("R6 idx", uframe_idx, 0);
        sof_after(P, 11'd101);
        chk_eq("R8 on-time idx", uframe_idx, 1);
        // R8 early SOF on the wrap cycle advances only once
        sof_after(P - 1, 11'd101);
        chk_eq("R8 wrap-coincident idx", uframe_idx, 2);
        // R3 late edge of window
        sof_after(P + WIN - 1, 11'd101);
        chk_eq("R3 late idx", uframe_idx, 3);
        chk_eq("R3 late sync", uframe_sync, 1);
        // R3 early edge of window
        sof_after(P - WIN, 11'd101);
        chk_eq("R3 early idx", uframe_idx, 4);
        // R4 out-of-window SOF with a would-be zeroth frame number is ignored
        sof_after(P + WIN + 1, 11'd102);
        chk_eq("R4 idx", uframe_idx, 5);
        chk_eq("R4 frame_sync", frame_sync, 1);
        sof_after(P - WIN - 1, 11'd101);
        chk_eq("R4 realign idx", uframe_idx, 6);
        // R9 frame numbers jump: frame lock kept, index keeps running
        sof_after(P, 11'd500);
        chk_eq("R9 idx", uframe_idx, 7);
        sof_after(P, 11'd777);
        chk_eq("R9 frame_sync", frame_sync, 1);
        chk_eq("R8 idx wrap", uframe_idx, 0);
        // R5 two misses then an on-time SOF keeps lock
        sof_after(3 * P, 11'd777);
        chk_eq("R5 two misses sync", uframe_sync, 1);
        chk_eq("R5 two misses idx", uframe_idx, 3);
        // R5/R10 three misses drop lock in the detection cycle
        repeat (3 * P + WIN - 1) cyc(1'b0, '0);
        chk_eq("R5 before third miss", uframe_sync, 1);
        cyc(1'b0, '0);
        chk_eq("R5 after third miss", uframe_sync, 0);
        chk_eq("R10 frame_sync", frame_sync, 0);
        chk_eq("R10 idx", uframe_idx, 0);
        chk_eq("R10 upstream_en", upstream_en, 0);

        // R7 a missed microframe between SOFs gives no frame lock
        cyc(1'b1, 11'd10);
        sof_after(2 * P, 11'd11);
        chk_eq("R7 gap frame_sync", frame_sync, 0);
        sof_after(P, 11'd12);
        chk_eq("R6 after gap frame_sync", frame_sync, 1);
        chk_eq("R6 after gap idx", uframe_idx, 0);
        repeat (3 * P + WIN) cyc(1'b0, '0);
        chk_eq("R10 unlock again", uframe_sync, 0);

        // Random in-window jitter across the 2047 -> 0 rollover
        m0 = int'($urandom_range(7));
        seen0 = 1'b0;
        for (int k = 0; k < 200; k++) begin
            int d;
            int pos;
            pos = m0 + k;
            d = int'($urandom_range(2 * WIN - 1)) - WIN;
            if (k == 0) cyc(1'b1, fnum_at(2047, pos));
            else        sof_after(P + d, fnum_at(2047, pos));
            if (k > 0 && pos % 8 == 0) seen0 = 1'b1;
            chk_eq("R3 random sync", uframe_sync, 1);
            chk_eq("R6 random frame_sync", frame_sync, int'(seen0));
            if (seen0) chk_eq("R8 random idx", uframe_idx, pos % 8);
            chk_eq("R11 random upstream_en", upstream_en, int'(uframe_sync));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule